// File: doc/BRIEF.md
# Processor Tick Timer with Compare Interrupt

This block is a free-running cycle counter paired with a one-shot compare register. It is built for a processor core, and the same design serves as the core tick timer, the system tick timer or the hypervisor system tick timer. A parameter picks which of these roles an instance plays. Software reads and writes the counter and the limit through a small register port. The top bit of each 64-bit word is a flag and is stored apart from the 63-bit value below it. On the counter, that flag marks the count as privileged (non-privileged trap). On the limit, it masks the interrupt.

When the timer is armed and the count reaches the limit, the block sets its bit in a soft-interrupt vector. In the same cycle it raises a one-cycle wake pulse toward a halted core. The comparison is "count at or above limit", so a limit written in the past still fires on the next step. A counter rewritten beyond the limit also fires. A match fires once and then disarms until the limit is written again. Soft-interrupt bits are sticky. They are cleared only by a masked clear strobe.

Top module: `tick_timer_unit`

## Requirements
- R1: After synchronous reset, the count is 0, the count flag (read bit 63) is 1, the limit value is 0, the limit disable flag (read bit 63) is 1, the soft-interrupt vector is all zero and the wake output is 0.
- R2: Without a counter write, the count rises by one on every clock edge and wraps from 2^63-1 to 0 with no other effect.
- R3: A counter write (reg_sel = 0) loads wdata bits 62:0 as the new count and wdata bit 63 as the count flag. Counting resumes from the loaded value on the following edge.
- R4: With reg_rsel = 0, reg_rdata returns the count in bits 62:0 and the count flag in bit 63.
- R5: A limit write (reg_sel = 1) stores wdata bits 62:0 as the compare value and bit 63 as the disable flag. With reg_rsel = 1, both are read back in the same positions.
- R6: A limit write with a nonzero compare value and a clear disable flag arms the timer. On the first edge at which the armed timer's count is at or above the compare value, the soft-interrupt bit is set and wake_o is high for exactly one cycle. The timer then disarms.
- R7: A limit write with a zero compare value or a set disable flag disarms the timer. A match that was pending is cancelled, and no interrupt or wake follows.
- R8: If the compare value is already at or below the count when the timer is armed, the match fires on the next edge. Rewriting the counter to a value at or beyond an armed compare value also fires on the next edge.
- R9: The tick role sets soft-interrupt bit 0. The system and hypervisor tick roles set bit 16.
- R10: Soft-interrupt bits stay set until sint_clr is high with the matching bit set in sint_clr_mask. When a match and a clear hit the same bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one count step per edge |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 counter, 1 limit |
| reg_wdata | input | 64 | Write data; bit 63 is the flag |
| reg_rsel | input | 1 | Read source: 0 counter, 1 limit |
| reg_rdata | output | 64 | Read data; bit 63 is the flag |
| sint_clr | input | 1 | Soft-interrupt clear strobe |
| sint_clr_mask | input | 17 | Bits to clear when sint_clr is high |
| sint_o | output | 17 | Sticky soft-interrupt vector |
| wake_o | output | 1 | One-cycle wake pulse to a halted core |

## Verification
A corrupted count or flag shows up on reg_rdata in the very next cycle that reads the counter. A wrong arm state or compare value shows up as a wake pulse that comes one or more cycles early or late, or that never comes, relative to the moment the count reaches the limit. Because the bench model tracks count, limit and arm state every cycle, a mistimed match is caught on the edge where it happens. A stuck or lost soft-interrupt bit is visible on sint_o as soon as the match edge or clear edge has passed.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Role of one timer instance
    typedef enum logic [1:0] {
        KIND_TICK   = 2'd0,
        KIND_STICK  = 2'd1,
        KIND_HSTICK = 2'd2
    } tick_kind_e;

    // Register port selector codes
    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;

    // Soft-interrupt bit positions decoded by the trap logic
    localparam int SINT_TIMER_BIT  = 0;
    localparam int SINT_STIMER_BIT = 16;

    // Decoded register-port action for one cycle
    typedef struct packed {
        logic wr_count;
        logic wr_limit;
    } reg_op_t;

    function automatic int sint_bit(tick_kind_e kind);
        return (kind == KIND_TICK) ? SINT_TIMER_BIT : SINT_STIMER_BIT;
    endfunction

endpackage

// File: rtl/tick_count.sv
module tick_count #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_flag,
    output logic [CNT_W-1:0] cnt_o,
    output logic             npt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             npt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            npt_q <= 1'b1;
        end else if (load) begin
            cnt_q <= load_val;
            npt_q <= load_flag;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
    assign npt_o = npt_q;

endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             wr_dis,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             dis_o,
    output logic             fire_o
);

    logic [CNT_W-1:0] cmp_q;
    logic             dis_q;
    logic             armed_q;
    logic             due;

    // At-or-above test: a limit in the past or a count jump never loses a match
    assign due    = (cnt_i >= cmp_q);
    assign fire_o = armed_q && due;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q   <= '0;
            dis_q   <= 1'b1;
            armed_q <= 1'b0;
        end else if (wr) begin
            cmp_q   <= wr_val;
            dis_q   <= wr_dis;
            armed_q <= (wr_val != '0) && !wr_dis;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end
    end

    assign cmp_o = cmp_q;
    assign dis_o = dis_q;

endmodule

// File: rtl/tick_sint.sv
module tick_sint #(
    parameter int SINT_W = 17,
    parameter int SET_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              clr,
    input  logic [SINT_W-1:0] clr_mask,
    output logic [SINT_W-1:0] sint_o,
    output logic              wake_o
);

    logic [SINT_W-1:0] sint_q;
    logic              wake_q;

    for (genvar i = 0; i < SINT_W; i++) begin : g_bit
        if (i == SET_BIT) begin : g_live
            always_ff @(posedge clk) begin
                if (rst)                      sint_q[i] <= 1'b0;
                else if (set)                 sint_q[i] <= 1'b1;
                else if (clr && clr_mask[i])  sint_q[i] <= 1'b0;
            end
        end else begin : g_other
            always_ff @(posedge clk) begin
                if (rst)                      sint_q[i] <= 1'b0;
                else if (clr && clr_mask[i])  sint_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= set;
    end

    assign sint_o = sint_q;
    assign wake_o = wake_q;

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import tick_timer_pkg::*;
#(
    parameter int         CNT_W  = 63,
    parameter int         SINT_W = 17,
    parameter tick_kind_e KIND   = KIND_TICK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CNT_W:0]    reg_wdata,
    input  logic              reg_rsel,
    output logic [CNT_W:0]    reg_rdata,
    input  logic              sint_clr,
    input  logic [SINT_W-1:0] sint_clr_mask,
    output logic [SINT_W-1:0] sint_o,
    output logic              wake_o
);

    localparam int SBIT = sint_bit(KIND);

    reg_op_t          op;
    logic [CNT_W-1:0] cnt_q;
    logic             npt_q;
    logic [CNT_W-1:0] lim_val;
    logic             lim_dis;
    logic             fire;

    always_comb begin
        op.wr_count = reg_wr && (reg_sel == SEL_COUNT);
        op.wr_limit = reg_wr && (reg_sel == SEL_LIMIT);
    end

    tick_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .load      (op.wr_count),
        .load_val  (reg_wdata[CNT_W-1:0]),
        .load_flag (reg_wdata[CNT_W]),
        .cnt_o     (cnt_q),
        .npt_o     (npt_q)
    );

    tick_compare #(.CNT_W(CNT_W)) u_compare (
        .clk    (clk),
        .rst    (rst),
        .wr     (op.wr_limit),
        .wr_val (reg_wdata[CNT_W-1:0]),
        .wr_dis (reg_wdata[CNT_W]),
        .cnt_i  (cnt_q),
        .cmp_o  (lim_val),
        .dis_o  (lim_dis),
        .fire_o (fire)
    );

    tick_sint #(.SINT_W(SINT_W), .SET_BIT(SBIT)) u_sint (
        .clk      (clk),
        .rst      (rst),
        .set      (fire),
        .clr      (sint_clr),
        .clr_mask (sint_clr_mask),
        .sint_o   (sint_o),
        .wake_o   (wake_o)
    );

    assign reg_rdata = (reg_rsel == SEL_LIMIT) ? {lim_dis, lim_val} : {npt_q, cnt_q};

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W  = 63,
    parameter int SINT_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [CNT_W:0]    reg_wdata,
    input logic              sint_clr,
    input logic [SINT_W-1:0] sint_o,
    input logic              wake_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              lim_dis
);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_sel == 1'b0) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R3
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 1'b0) |=> cnt_q == $past(reg_wdata[CNT_W-1:0]));

    // R6
    wake_has_sint_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (sint_o != '0));

    // R7
    disabled_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
        lim_dis |=> !wake_o);

    // R10
    sint_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !sint_clr |=> (sint_o & $past(sint_o)) == $past(sint_o));

endmodule

bind tick_timer_unit tick_timer_chk #(.CNT_W(CNT_W), .SINT_W(SINT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .sint_clr  (sint_clr),
    .sint_o    (sint_o),
    .wake_o    (wake_o),
    .cnt_q     (cnt_q),
    .lim_dis   (lim_dis)
);

// File: tb/test_tick_timer_unit.sv
module test_tick_timer_unit;
    import tick_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rsel = 1'b0;
    logic        sint_clr = 1'b0;
    logic [16:0] sint_clr_mask = '0;
    logic [63:0] rd_t, rd_s;
    logic [16:0] sint_t, sint_s;
    logic        wake_t, wake_s;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tick_timer_unit #(.KIND(KIND_TICK)) i_tick_timer_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(rd_t),
        .sint_clr(sint_clr), .sint_clr_mask(sint_clr_mask),
        .sint_o(sint_t), .wake_o(wake_t));

    tick_timer_unit #(.KIND(KIND_STICK)) i_tick_timer_unit_sys (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(rd_s),
        .sint_clr(sint_clr), .sint_clr_mask(sint_clr_mask),
        .sint_o(sint_s), .wake_o(wake_s));

    // Behavioural reference: plain variables, updated once per edge
    logic [62:0] m_cnt, m_cmp;
    logic        m_npt, m_dis, m_armed, m_wake, m_fire;
    logic [16:0] m_sint_t, m_sint_s;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_npt = 1; m_cmp = 0; m_dis = 1; m_armed = 0;
            m_wake = 0; m_sint_t = 0; m_sint_s = 0;
        end else begin
            m_fire = m_armed && (m_cnt >= m_cmp);
            if (sint_clr) begin
                m_sint_t = m_sint_t & ~sint_clr_mask;
                m_sint_s = m_sint_s & ~sint_clr_mask;
            end
            if (m_fire) begin
                m_sint_t[0]  = 1'b1;
                m_sint_s[16] = 1'b1;
            end
            m_wake = m_fire;
            if (reg_wr && !reg_sel) begin
                m_cnt = reg_wdata[62:0];
                m_npt = reg_wdata[63];
            end else begin
                m_cnt = m_cnt + 63'd1;
            end
            if (reg_wr && reg_sel) begin
                m_cmp   = reg_wdata[62:0];
                m_dis   = reg_wdata[63];
                m_armed = (m_cmp != 0) && !m_dis;
            end else if (m_fire) begin
                m_armed = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance one edge, then compare every output with the model
    task automatic step();
        @(posedge clk);
        #1;
        chk("R4 model rdata", rd_t, reg_rsel ? {m_dis, m_cmp} : {m_npt, m_cnt});
        chk("R9 model sint tick", {47'd0, sint_t}, {47'd0, m_sint_t});
        chk("R9 model sint sys", {47'd0, sint_s}, {47'd0, m_sint_s});
        chk("R6 model wake", {63'd0, wake_t}, {63'd0, m_wake});
        chk("R6 model wake sys", {63'd0, wake_s}, {63'd0, m_wake});
    endtask

    task automatic wr_reg(input logic sel, input logic [63:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic read_cnt(output logic [62:0] c);
        reg_rsel = 1'b0; #1;
        c = rd_t[62:0];
    endtask

    task automatic wait_wake(input string req);
        int k;
        k = 0;
        while (wake_t !== 1'b1 && k < 200) begin step(); k++; end
        if (wake_t !== 1'b1) chk(req, 64'd0, 64'd1);
    endtask

    initial begin
        logic [62:0] c;
        int wakes;
        repeat (3) step();
        // R1 reset state
        reg_rsel = 1'b0; #1;
        chk("R1 count after reset", rd_t, 64'h8000_0000_0000_0000);
        reg_rsel = 1'b1; #1;
        chk("R1 limit after reset", rd_t, 64'h8000_0000_0000_0000);
        chk("R1 sint after reset", {47'd0, sint_t}, 64'd0);
        chk("R1 wake after reset", {63'd0, wake_t}, 64'd0);
        reg_rsel = 1'b0;
        rst = 1'b0;
        repeat (10) step();
        chk("R2 count after ten edges", rd_t, 64'h8000_0000_0000_000A);

        wr_reg(SEL_COUNT, 64'd100);
        chk("R3 R4 counter load", rd_t, 64'd100);
        step();
        chk("R2 step after load", rd_t, 64'd101);
        wr_reg(SEL_COUNT, 64'h8000_0000_0000_00C8);
        chk("R4 flag on read", rd_t, 64'h8000_0000_0000_00C8);

        // R6 normal match with compare 230
        wr_reg(SEL_LIMIT, 64'd230);
        wait_wake("R6 match never seen");
        chk("R6 count at wake", rd_t, 64'h8000_0000_0000_00E7);
        chk("R9 tick bit 0", {47'd0, sint_t}, 64'h1);
        chk("R9 system bit 16", {47'd0, sint_s}, 64'h10000);
        step();
        chk("R6 wake one cycle", {63'd0, wake_t}, 64'd0);
        wakes = 0;
        repeat (40) begin step(); if (wake_t) wakes++; end
        chk("R6 fires once", wakes, 0);
        chk("R10 bit stays set", {47'd0, sint_t}, 64'h1);
        sint_clr = 1'b1; sint_clr_mask = 17'h1FFFF;
        step();
        sint_clr = 1'b0;
        chk("R10 cleared tick", {47'd0, sint_t}, 64'd0);
        chk("R10 cleared sys", {47'd0, sint_s}, 64'd0);

        // R7 disabled and zero limits
        read_cnt(c);
        wr_reg(SEL_LIMIT, {1'b1, c + 63'd10});
        reg_rsel = 1'b1; #1;
        chk("R5 limit readback disabled", rd_t, {1'b1, c + 63'd10});
        reg_rsel = 1'b0;
        wakes = 0;
        repeat (30) begin step(); if (wake_t) wakes++; end
        chk("R7 disabled no wake", wakes, 0);
        read_cnt(c);
        wr_reg(SEL_LIMIT, {1'b0, c + 63'd8});
        wr_reg(SEL_LIMIT, 64'd0);
        wakes = 0;
        repeat (30) begin step(); if (wake_t) wakes++; end
        chk("R7 zero limit cancels", wakes, 0);
        chk("R7 no sint", {47'd0, sint_t}, 64'd0);

        // R8 limit already in the past
        read_cnt(c);
        wr_reg(SEL_LIMIT, {1'b0, c - 63'd50});
        chk("R8 no wake at write", {63'd0, wake_t}, 64'd0);
        step();
        chk("R8 past limit fires next", {63'd0, wake_t}, 64'd1);
        // R8 counter rewritten beyond the limit
        read_cnt(c);
        wr_reg(SEL_LIMIT, {1'b0, c + 63'd1000});
        wr_reg(SEL_COUNT, {1'b0, c + 63'd2000});
        step();
        chk("R8 jump past limit fires", {63'd0, wake_t}, 64'd1);

        // R10 set wins over a same-edge clear
        read_cnt(c);
        wr_reg(SEL_LIMIT, {1'b0, c + 63'd6});
        sint_clr = 1'b1; sint_clr_mask = 17'h1FFFF;
        wait_wake("R10 match never seen");
        chk("R10 set wins over clear", {47'd0, sint_t}, 64'h1);
        step();
        chk("R10 clear next edge", {47'd0, sint_t}, 64'd0);
        sint_clr = 1'b0;

        // R2 wrap at the top of the count
        wr_reg(SEL_COUNT, 64'h7FFF_FFFF_FFFF_FFFE);
        step();
        chk("R2 before wrap", rd_t, 64'h7FFF_FFFF_FFFF_FFFF);
        step();
        chk("R2 wrap to zero", rd_t, 64'd0);

        wr_reg(SEL_LIMIT, 64'h0000_0001_2345_6789);
        reg_rsel = 1'b1; #1;
        chk("R5 limit readback enabled", rd_t, 64'h0000_0001_2345_6789);
        step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule